// File: doc/BRIEF.md
# Packed Equality Compare Unit

This block is the execution stage for a family of packed-integer "compare for equal" operations. Each cycle it can accept one operation: a valid strobe, the opcode byte that follows the two-byte escape, a flag that says whether the operand-size prefix was present, and two operands up to 128 bits wide. The opcode selects the element size: bytes, 16-bit words or 32-bit doublewords. The prefix flag selects the operation width: a 128-bit operation on the wide register class, or a 64-bit operation on the narrow register class.

Every element pair is compared. Each destination field becomes all ones when the two fields are equal and all zeros when they differ. The result is written to a register, so it appears one cycle after the strobe together with a valid flag. An unknown opcode raises an illegal-operation flag instead of the valid flag, and the result register is left as it was. The operation changes no status flags, so the unit has no flag output. Operand fetch, register-file access, memory access and fault detection are handled elsewhere.

Top module: `pcmpeq_unit`

## Requirements
- R1: The opcode byte sets the element size. 0x74 gives 8-bit elements, 0x75 gives 16-bit elements and 0x76 gives 32-bit elements.
- R2: When in_wide is 1 the operation is 128 bits wide, with 16, 8 or 4 elements. When in_wide is 0 it is 64 bits wide, with 8, 4 or 2 elements.
- R3: Element i of width W occupies bits [i*W+W-1 : i*W] of both operands and of the result. The result field is all ones when the two operand fields are equal. It is all zeros when they differ in any bit, including a single bit.
- R4: In a 64-bit operation, out_result[127:64] is zero, even where the upper operand halves match.
- R5: An accepted strobe with any other opcode byte (for example 0x73, 0x77 or 0xF4) sets out_illegal high for one cycle and keeps out_valid low. out_result keeps its previous value.
- R6: A legal operation gives out_valid high exactly one clock edge after the strobe. In a cycle after an edge with in_valid low, out_valid and out_illegal are both low.
- R7: A synchronous active-high reset clears out_valid, out_illegal and out_result to zero, and it takes priority over a strobe in the same cycle.
- R8: out_result changes only on a legal operation or on reset. It holds its value through idle cycles and illegal operations.
- R9: In a 64-bit operation, operand bits [127:64] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_opcode | input | 8 | Opcode byte that follows the escape |
| in_wide | input | 1 | Operand-size prefix present: 1 = 128-bit operation, 0 = 64-bit operation |
| in_a | input | 128 | First operand, which is also the destination |
| in_b | input | 128 | Second operand (source) |
| out_valid | output | 1 | Result valid, one cycle after a legal operation |
| out_illegal | output | 1 | Unknown opcode, one cycle after the strobe |
| out_result | output | 128 | Registered element mask |

## Verification
The operands are applied in several patterns, and each pattern separates one kind of fault.
- Identical operands and fully inverted operands establish the two extremes of all ones and all zeros.
- Operands that differ in chosen bytes are run at each element size. The same difference must clear one byte, a whole word or a whole doubleword, so a wrong grouping of lanes shows up.
- Narrow operations are given upper halves that both match and mismatch. This separates correct zeroing of bits [127:64] from results that leak the upper comparison.
- Illegal opcodes, idle gaps and a reset applied with a strobe present check the flag timing and the holding of the result register.
- A pseudo-random stream of mixed opcodes and widths follows, compared against an independent model.

// File: rtl/pcmpeq_pkg.sv
package pcmpeq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OPC_EQ_BYTE  = 8'h74;
    localparam logic [7:0] OPC_EQ_WORD  = 8'h75;
    localparam logic [7:0] OPC_EQ_DWORD = 8'h76;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_WORD  = 2'd1,
        ESZ_DWORD = 2'd2
    } esz_e;

    typedef struct packed {
        logic legal;
        logic wide;
        esz_e esz;
    } dec_t;

    function automatic dec_t decode_op(input logic [7:0] opc, input logic wide_pfx);
        dec_t d;
        d.wide  = wide_pfx;
        d.legal = 1'b1;
        unique case (opc)
            OPC_EQ_BYTE:  d.esz = ESZ_BYTE;
            OPC_EQ_WORD:  d.esz = ESZ_WORD;
            OPC_EQ_DWORD: d.esz = ESZ_DWORD;
            default: begin
                d.esz   = ESZ_BYTE;
                d.legal = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pcmpeq_decode.sv
module pcmpeq_decode
    import pcmpeq_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       wide_pfx,
    output dec_t       dec
);

    always_comb begin
        dec = decode_op(opcode, wide_pfx);
    end

endmodule

// File: rtl/pcmpeq_lanes.sv
module pcmpeq_lanes
    import pcmpeq_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  dec_t              dec,
    output logic [DATA_W-1:0] mask
);

    localparam int NB       = DATA_W / BYTE_W;
    localparam int NW       = NB / 2;
    localparam int ND       = NB / 4;
    localparam int NARROW_B = NB / 2;

    logic [NB-1:0] byte_eq;
    logic [NW-1:0] word_eq;
    logic [ND-1:0] dword_eq;

    // Byte comparators are shared by all three element sizes
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign byte_eq[i] = (opa[i*BYTE_W +: BYTE_W] == opb[i*BYTE_W +: BYTE_W]);
    end

    for (genvar j = 0; j < NW; j++) begin : g_word
        assign word_eq[j] = byte_eq[2*j] & byte_eq[2*j+1];
    end

    for (genvar k = 0; k < ND; k++) begin : g_dword
        assign dword_eq[k] = word_eq[2*k] & word_eq[2*k+1];
    end

    for (genvar i = 0; i < NB; i++) begin : g_sel
        logic hit;
        always_comb begin
            unique case (dec.esz)
                ESZ_BYTE: hit = byte_eq[i];
                ESZ_WORD: hit = word_eq[i/2];
                default:  hit = dword_eq[i/4];
            endcase
        end
        if (i >= NARROW_B) begin : g_upper
            assign mask[i*BYTE_W +: BYTE_W] = {BYTE_W{hit & dec.wide}};
        end else begin : g_lower
            assign mask[i*BYTE_W +: BYTE_W] = {BYTE_W{hit}};
        end
    end

endmodule

// File: rtl/pcmpeq_outreg.sv
module pcmpeq_outreg #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              legal,
    input  logic [DATA_W-1:0] mask,
    output logic              valid_q,
    output logic              illegal_q,
    output logic [DATA_W-1:0] result_q
);

    logic accept;
    assign accept = strobe & legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            result_q  <= '0;
        end else begin
            valid_q   <= accept;
            illegal_q <= strobe & ~legal;
            if (accept) begin
                result_q <= mask;
            end
        end
    end

endmodule

// File: rtl/pcmpeq_unit.sv
module pcmpeq_unit
    import pcmpeq_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_opcode,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [DATA_W-1:0] out_result
);

    dec_t              dec;
    logic [DATA_W-1:0] mask;

    pcmpeq_decode u_dec (
        .opcode   (in_opcode),
        .wide_pfx (in_wide),
        .dec      (dec)
    );

    pcmpeq_lanes #(.DATA_W(DATA_W)) u_lanes (
        .opa  (in_a),
        .opb  (in_b),
        .dec  (dec),
        .mask (mask)
    );

    pcmpeq_outreg #(.DATA_W(DATA_W)) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .strobe    (in_valid),
        .legal     (dec.legal),
        .mask      (mask),
        .valid_q   (out_valid),
        .illegal_q (out_illegal),
        .result_q  (out_result)
    );

endmodule

// File: rtl/pcmpeq_checker.sv
module pcmpeq_checker #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        in_opcode,
    input logic              in_wide,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [DATA_W-1:0] out_result
);

    localparam int NB = DATA_W / 8;

    logic known_opc;
    assign known_opc = (in_opcode == 8'h74) || (in_opcode == 8'h75) || (in_opcode == 8'h76);

    function automatic logic saturated(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    assert_accept_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && known_opc) |=> (out_valid && !out_illegal));

    assert_reject_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !known_opc) |=> (out_illegal && !out_valid && $stable(out_result)));

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && known_opc) |=> $stable(out_result));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && known_opc && !in_wide) |=> (out_result[DATA_W-1:DATA_W/2] == '0));

    assert_saturated_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> saturated(out_result));

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_result == '0));

endmodule

bind pcmpeq_unit pcmpeq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_wide     (in_wide),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
);

// File: tb/tb_pcmpeq_unit.sv
module tb_pcmpeq_unit;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [7:0]   in_opcode;
    logic         in_wide;
    logic [127:0] in_a;
    logic [127:0] in_b;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_result;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcmpeq_unit dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_opcode   (in_opcode),
        .in_wide     (in_wide),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_result  (out_result)
    );

    typedef struct {
        logic         v;
        logic         ill;
        logic [127:0] res;
    } exp_t;

    exp_t   exp_q[$];
    string  tag_q[$];
    int     n_checks = 0;
    int     n_fail   = 0;
    logic [127:0] model_res = '0;
    logic [63:0]  lfsr = 64'h9E37_79B9_7F4A_7C15;

    function automatic logic [127:0] model_cmp(input logic [7:0] opc, input logic w,
                                               input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        int eb;
        int nb;
        r  = '0;
        eb = (opc == 8'h74) ? 1 : (opc == 8'h75) ? 2 : 4;
        nb = w ? 16 : 8;
        for (int k = 0; k < nb; k++) begin
            int  base;
            logic eq;
            base = (k / eb) * eb;
            eq = 1'b1;
            for (int j = 0; j < eb; j++) begin
                if (a[(base+j)*8 +: 8] != b[(base+j)*8 +: 8]) eq = 1'b0;
            end
            r[k*8 +: 8] = {8{eq}};
        end
        return r;
    endfunction

    function automatic logic [127:0] flip_bytes(input logic [127:0] a, input logic [15:0] sel);
        logic [127:0] r;
        r = a;
        for (int k = 0; k < 16; k++) begin
            if (sel[k]) r[k*8 +: 8] = a[k*8 +: 8] ^ 8'h5A;
        end
        return r;
    endfunction

    task automatic op(input logic v, input logic [7:0] opc, input logic w,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
        exp_t e;
        logic legal;
        @(negedge clk);
        rst       = 1'b0;
        in_valid  = v;
        in_opcode = opc;
        in_wide   = w;
        in_a      = a;
        in_b      = b;
        legal = (opc == 8'h74) || (opc == 8'h75) || (opc == 8'h76);
        if (v && legal) model_res = model_cmp(opc, w, a, b);
        e.v   = v && legal;
        e.ill = v && !legal;
        e.res = model_res;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic sync_reset_with_strobe();
        exp_t e;
        @(negedge clk);
        rst       = 1'b1;
        in_valid  = 1'b1;
        in_opcode = 8'h74;
        in_wide   = 1'b1;
        in_a      = '1;
        in_b      = '1;
        model_res = '0;
        e.v = 1'b0; e.ill = 1'b0; e.res = '0;
        exp_q.push_back(e);
        tag_q.push_back("R7 reset beats strobe");
    endtask

    // Monitor: sample a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (out_valid !== e.v || out_illegal !== e.ill || out_result !== e.res) begin
                    n_fail++;
                    $display("FAIL %s: actual v=%b ill=%b res=%h expected v=%b ill=%b res=%h",
                             t, out_valid, out_illegal, out_result, e.v, e.ill, e.res);
                end
            end
        end
    end

    logic done = 1'b0;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] pa;
        logic [127:0] pb;
        pa = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
        rst = 1'b1; in_valid = 1'b0; in_opcode = 8'h00; in_wide = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        n_checks++;
        if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0) begin
            n_fail++;
            $display("FAIL R7 reset state: actual v=%b ill=%b res=%h expected 0 0 0",
                     out_valid, out_illegal, out_result);
        end

        // R1 R2 R3: byte elements, wide, bytes 3 and 9 differ
        op(1, 8'h74, 1, pa, flip_bytes(pa, 16'h0208), "R1 R3 byte wide");
        // R1 R3: word elements, same difference clears words 1 and 4
        op(1, 8'h75, 1, pa, flip_bytes(pa, 16'h0208), "R1 R3 word wide");
        // R1 R3: dword elements clear dwords 0 and 2
        op(1, 8'h76, 1, pa, flip_bytes(pa, 16'h0208), "R1 R3 dword wide");
        // R3: all equal and all different
        op(1, 8'h76, 1, pa, pa, "R3 all equal");
        op(1, 8'h74, 1, pa, ~pa, "R3 all differ");
        // R3: single-bit difference inside dword 1
        op(1, 8'h76, 1, pa, pa ^ 128'h0000_0000_0000_0000_0000_0100_0000_0000, "R3 one bit dword");
        op(1, 8'h75, 1, pa, pa ^ 128'h8000_0000_0000_0000_0000_0000_0000_0000, "R3 one bit top word");
        // R2 R4 R9: narrow with equal lower half, differing upper half
        op(1, 8'h74, 0, pa, {~pa[127:64], pa[63:0]}, "R2 R9 narrow upper differ");
        // R4: narrow with fully equal operands leaves upper half zero
        op(1, 8'h75, 0, pa, pa, "R4 narrow upper zero");
        op(1, 8'h76, 0, pa, flip_bytes(pa, 16'h0010), "R2 R4 narrow dword");
        // R5: illegal opcodes hold result
        op(1, 8'h77, 1, pa, pa, "R5 illegal 0x77");
        op(1, 8'h73, 0, pa, ~pa, "R5 illegal 0x73");
        op(1, 8'hF4, 1, '0, '1, "R5 illegal 0xF4");
        // R6 R8: idle cycles, inputs changing
        op(0, 8'h74, 1, '0, '1, "R6 R8 idle");
        op(0, 8'h76, 0, pa, pa, "R6 R8 idle");
        op(1, 8'h74, 1, '0, '0, "R6 back to back");
        op(1, 8'h74, 1, '0, '1, "R6 back to back");
        // R7: reset while a strobe is present
        sync_reset_with_strobe();
        op(0, 8'h74, 1, '0, '0, "R7 after reset");

        // Mixed pseudo-random stream
        for (int n = 0; n < 200; n++) begin
            logic [7:0] opc;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            pa[63:0] = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            pa[127:64] = lfsr;
            pb = flip_bytes(pa, lfsr[15:0] & lfsr[31:16] & lfsr[47:32]);
            opc = 8'h74 + {6'd0, lfsr[49:48]};
            op(lfsr[52] | lfsr[53], opc, lfsr[50], pa, pb, "R1 R2 R3 R8 random");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6 pending results: actual %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule